// File: doc/BRIEF.md
# DDS Command Register Slave

This block is the serial front end of a direct digital synthesis core. A host sends 16-bit command words over an SPI link. Each word sits inside its own chip-select frame, and chip select goes high between words. The block decodes each word into three fields: a command in bits 15:12, a register address in bits 11:8 and a data byte in bits 7:0. From these it keeps two 32-bit frequency tuning words, four 12-bit phase offsets and a small set of control flags, and drives them straight to a downstream oscillator core.

Wide registers are loaded in two steps. A staging command only stores its data byte in a single shared holding byte. A later commit command writes that held byte and its own data byte into a register as one 16-bit pair: the held byte goes to the odd byte address and the new byte to the even address just below it. This way, no half-written tuning word ever reaches the oscillator.

The SPI pins are taken through synchronisers into the system clock domain. A word takes effect only when exactly sixteen serial clocks arrive inside one frame.

Top module: `dds_cmd_slave`

## Requirements
- R1: After reset, both frequency words, all four phase offsets, the held byte, the frequency-select, phase-select, source-select and sync outputs are 0, and sleep, core reset and clear are 1.
- R2: Serial data is captured MSB first on rising serial clock edges while chip select is low. A frame with any count other than 16 rising edges (15 or 17, for example) changes no output.
- R3: Command 0x1 and command 0x3 load the data byte into the holding byte and change no output.
- R4: Command 0x2 with address bit 3 clear writes {held byte, data byte} into bits 31:16 of a frequency word when address bit 1 is 1, and into bits 15:0 when it is 0. Address bit 2 picks frequency word 1 over word 0.
- R5: Command 0x0 with address bit 3 set writes {held byte bits 3:0, data byte} into the 12-bit phase offset numbered by address bits 2:1.
- R6: A commit reuses whatever byte is held. If no staging command came since the previous commit, the previous held byte is used again.
- R7: Command 0x6 sets frequency select from word bit 11 and phase select from word bits 10:9.
- R8: Any word whose bits 15:14 are 2'b10 sets sync from bit 13 and source select from bit 12. A 1 in bit 12 means register-controlled selection.
- R9: Any word whose bits 15:14 are 2'b11 sets sleep from bit 13, core reset from bit 12 and clear from bit 11.
- R10: The following words change no output:
  - command codes 0x4, 0x5 and 0x7;
  - command 0x2 with address bit 3 set;
  - command 0x0 with address bit 3 clear.
- R11: Outputs change only on the third rising system clock edge after chip select rises at the end of a valid frame, and hold at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select, one word per frame |
| spi_mosi | input | 1 | Serial data in, MSB first |
| freq0_o | output | 32 | Frequency tuning word 0 |
| freq1_o | output | 32 | Frequency tuning word 1 |
| phase0_o | output | 12 | Phase offset 0 |
| phase1_o | output | 12 | Phase offset 1 |
| phase2_o | output | 12 | Phase offset 2 |
| phase3_o | output | 12 | Phase offset 3 |
| freq_sel_o | output | 1 | Selects frequency word 1 when high |
| phase_sel_o | output | 2 | Selects the active phase offset |
| src_reg_o | output | 1 | Selection taken from registers instead of pins |
| sync_o | output | 1 | Sync flag |
| sleep_o | output | 1 | Sleep flag |
| core_reset_o | output | 1 | Oscillator core reset flag |
| clear_o | output | 1 | Clear flag |

## Verification
Full 32-bit frequency words are built from four transfers for both sets. This checks that the address bits pick the correct word and half, and that the held byte lands above the new one. Phase writes go to offsets 0, 1 and 3, including one commit with no fresh staging, which shows that the held byte is kept and masked to four bits. Frames of 15 and 17 clocks, unknown codes and commits to the wrong address range are mixed in between valid words, so any leak of a discarded word appears as a mismatch. Select, sync/source and power words are sent with several bit patterns each, so a swapped bit within a field gives a different value.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int FREQ_W  = 32;
  localparam int PHASE_W = 12;
  localparam int N_FREQ  = 2;
  localparam int N_PHASE = 4;
  localparam int PAIR_W  = 2 * BYTE_W;

  localparam logic [3:0] CMD_PH_COMMIT = 4'h0;
  localparam logic [3:0] CMD_PH_STAGE  = 4'h1;
  localparam logic [3:0] CMD_FR_COMMIT = 4'h2;
  localparam logic [3:0] CMD_FR_STAGE  = 4'h3;
  localparam logic [3:0] CMD_SELECT    = 4'h6;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [3:0]        addr;
    logic [BYTE_W-1:0] data;
  } cmd_word_t;

  // Replace one 16-bit half of a frequency word with a committed byte pair.
  function automatic logic [FREQ_W-1:0] merge_freq(input logic [FREQ_W-1:0] old,
                                                   input logic upper,
                                                   input logic [PAIR_W-1:0] pair);
    logic [FREQ_W-1:0] r;
    r = old;
    if (upper) r[FREQ_W-1:PAIR_W] = pair;
    else       r[PAIR_W-1:0]      = pair;
    return r;
  endfunction

  // Build a phase offset from the held byte (low bits only) and the new byte.
  function automatic logic [PHASE_W-1:0] merge_phase(input logic [BYTE_W-1:0] hi,
                                                     input logic [BYTE_W-1:0] lo);
    return {hi[PHASE_W-BYTE_W-1:0], lo};
  endfunction
endpackage

// File: rtl/dds_spi_rx.sv
module dds_spi_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [SYNC_STAGES:0] sclk_s, cs_s, mosi_s;
  logic [CNT_W-1:0]     bit_cnt;
  logic [WORD_W-1:0]    shift_q;
  logic                 sclk_rise, cs_rise, cs_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-1:0], sclk};
      cs_s   <= {cs_s[SYNC_STAGES-1:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-1:0], mosi};
    end
  end

  assign cs_hi     = cs_s[SYNC_STAGES-1];
  assign sclk_rise = sclk_s[SYNC_STAGES-1] & ~sclk_s[SYNC_STAGES] & ~cs_hi;
  assign cs_rise   = cs_hi & ~cs_s[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
    end else if (cs_hi) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shift_q <= {shift_q[WORD_W-2:0], mosi_s[SYNC_STAGES-1]};
      if (bit_cnt <= CNT_FULL) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign word_valid = cs_rise && (bit_cnt == CNT_FULL);
  assign word       = shift_q;
endmodule

// File: rtl/dds_cmd_decode.sv
module dds_cmd_decode
  import dds_cmd_pkg::*;
(
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              stage_en,
  output logic              fcommit_en,
  output logic              pcommit_en,
  output logic              select_en,
  output logic              srcsync_en,
  output logic              power_en,
  output logic [3:0]        addr,
  output logic [BYTE_W-1:0] data,
  output logic [2:0]        ctl_bits
);
  cmd_word_t w;
  assign w        = cmd_word_t'(word);
  assign addr     = w.addr;
  assign data     = w.data;
  assign ctl_bits = word[13:11];

  always_comb begin
    stage_en   = 1'b0;
    fcommit_en = 1'b0;
    pcommit_en = 1'b0;
    select_en  = 1'b0;
    srcsync_en = 1'b0;
    power_en   = 1'b0;
    if (word_valid) begin
      if (w.cmd[3:2] == 2'b11)      power_en   = 1'b1;
      else if (w.cmd[3:2] == 2'b10) srcsync_en = 1'b1;
      else begin
        case (w.cmd)
          CMD_PH_STAGE, CMD_FR_STAGE: stage_en   = 1'b1;
          CMD_FR_COMMIT:              fcommit_en = ~w.addr[3];
          CMD_PH_COMMIT:              pcommit_en = w.addr[3];
          CMD_SELECT:                 select_en  = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
  import dds_cmd_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               stage_en,
  input  logic                               fcommit_en,
  input  logic                               pcommit_en,
  input  logic                               select_en,
  input  logic                               srcsync_en,
  input  logic                               power_en,
  input  logic [3:0]                         addr,
  input  logic [BYTE_W-1:0]                  data,
  input  logic [2:0]                         ctl_bits,
  output logic [BYTE_W-1:0]                  held_byte,
  output logic [N_FREQ-1:0][FREQ_W-1:0]      freq_q,
  output logic [N_PHASE-1:0][PHASE_W-1:0]    phase_q,
  output logic                               freq_sel,
  output logic [1:0]                         phase_sel,
  output logic                               src_reg,
  output logic                               sync_flag,
  output logic                               sleep_flag,
  output logic                               reset_flag,
  output logic                               clear_flag
);
  localparam int FIDX_W = $clog2(N_FREQ);
  localparam int PIDX_W = $clog2(N_PHASE);

  logic [PAIR_W-1:0] pair;
  assign pair = {held_byte, data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_byte <= '0;
    else if (stage_en) held_byte <= data;
  end

  for (genvar f = 0; f < N_FREQ; f++) begin : g_freq
    logic [FREQ_W-1:0] f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= '0;
      else if (fcommit_en && addr[2 +: FIDX_W] == FIDX_W'(f))
        f_q <= merge_freq(f_q, addr[1], pair);
    end
    assign freq_q[f] = f_q;
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    logic [PHASE_W-1:0] p_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_q <= '0;
      else if (pcommit_en && addr[1 +: PIDX_W] == PIDX_W'(p))
        p_q <= merge_phase(held_byte, data);
    end
    assign phase_q[p] = p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_sel   <= 1'b0;
      phase_sel  <= 2'b00;
      src_reg    <= 1'b0;
      sync_flag  <= 1'b0;
      sleep_flag <= 1'b1;
      reset_flag <= 1'b1;
      clear_flag <= 1'b1;
    end else begin
      if (select_en) begin
        freq_sel  <= addr[3];
        phase_sel <= addr[2:1];
      end
      if (srcsync_en) begin
        sync_flag <= ctl_bits[2];
        src_reg   <= ctl_bits[1];
      end
      if (power_en) begin
        sleep_flag <= ctl_bits[2];
        reset_flag <= ctl_bits[1];
        clear_flag <= ctl_bits[0];
      end
    end
  end
endmodule

// File: rtl/dds_cmd_slave.sv
module dds_cmd_slave
  import dds_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic [31:0] freq0_o,
  output logic [31:0] freq1_o,
  output logic [11:0] phase0_o,
  output logic [11:0] phase1_o,
  output logic [11:0] phase2_o,
  output logic [11:0] phase3_o,
  output logic        freq_sel_o,
  output logic [1:0]  phase_sel_o,
  output logic        src_reg_o,
  output logic        sync_o,
  output logic        sleep_o,
  output logic        core_reset_o,
  output logic        clear_o
);
  logic                            word_valid;
  logic [WORD_W-1:0]               rx_word;
  logic                            stage_en, fcommit_en, pcommit_en;
  logic                            select_en, srcsync_en, power_en;
  logic [3:0]                      dec_addr;
  logic [BYTE_W-1:0]               dec_data;
  logic [2:0]                      dec_ctl;
  logic [BYTE_W-1:0]               held_byte;
  logic [N_FREQ-1:0][FREQ_W-1:0]   freq_q;
  logic [N_PHASE-1:0][PHASE_W-1:0] phase_q;

  dds_spi_rx #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .word_valid(word_valid), .word(rx_word)
  );

  dds_cmd_decode u_dec (
    .word_valid(word_valid), .word(rx_word),
    .stage_en(stage_en), .fcommit_en(fcommit_en), .pcommit_en(pcommit_en),
    .select_en(select_en), .srcsync_en(srcsync_en), .power_en(power_en),
    .addr(dec_addr), .data(dec_data), .ctl_bits(dec_ctl)
  );

  dds_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n),
    .stage_en(stage_en), .fcommit_en(fcommit_en), .pcommit_en(pcommit_en),
    .select_en(select_en), .srcsync_en(srcsync_en), .power_en(power_en),
    .addr(dec_addr), .data(dec_data), .ctl_bits(dec_ctl),
    .held_byte(held_byte), .freq_q(freq_q), .phase_q(phase_q),
    .freq_sel(freq_sel_o), .phase_sel(phase_sel_o), .src_reg(src_reg_o),
    .sync_flag(sync_o), .sleep_flag(sleep_o), .reset_flag(core_reset_o),
    .clear_flag(clear_o)
  );

  assign freq0_o  = freq_q[0];
  assign freq1_o  = freq_q[1];
  assign phase0_o = phase_q[0];
  assign phase1_o = phase_q[1];
  assign phase2_o = phase_q[2];
  assign phase3_o = phase_q[3];
endmodule

// File: rtl/dds_cmd_checker.sv
module dds_cmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic [15:0] rx_word,
  input logic [7:0]  held_byte,
  input logic [31:0] freq0_o,
  input logic [31:0] freq1_o,
  input logic [11:0] phase0_o,
  input logic [11:0] phase1_o,
  input logic [11:0] phase2_o,
  input logic [11:0] phase3_o,
  input logic        freq_sel_o,
  input logic [1:0]  phase_sel_o,
  input logic        src_reg_o,
  input logic        sync_o,
  input logic        sleep_o,
  input logic        core_reset_o,
  input logic        clear_o
);
  logic [3:0] cmd;
  logic       is_stage;
  logic [31:0] freq_now;
  logic [15:0] half_now;
  logic [11:0] phase_now;
  logic [2:0]  waddr;

  assign cmd      = rx_word[15:12];
  assign is_stage = (cmd == 4'h1) || (cmd == 4'h3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waddr <= '0;
    else        waddr <= rx_word[10:8];
  end

  always_comb begin
    freq_now = waddr[2] ? freq1_o : freq0_o;
    half_now = waddr[1] ? freq_now[31:16] : freq_now[15:0];
    case (waddr[2:1])
      2'd0:    phase_now = phase0_o;
      2'd1:    phase_now = phase1_o;
      2'd2:    phase_now = phase2_o;
      default: phase_now = phase3_o;
    endcase
  end

  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(freq0_o) && $stable(freq1_o) && $stable(phase0_o) &&
      $stable(phase1_o) && $stable(phase2_o) && $stable(phase3_o) &&
      $stable(freq_sel_o) && $stable(phase_sel_o) && $stable(src_reg_o) &&
      $stable(sync_o) && $stable(sleep_o) && $stable(core_reset_o) && $stable(clear_o)); // R11

  AST_STAGE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && is_stage |=> $stable(freq0_o) && $stable(freq1_o) &&
      $stable(phase0_o) && $stable(phase1_o) && $stable(phase2_o) && $stable(phase3_o)); // R3

  AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && is_stage |=> held_byte == $past(rx_word[7:0])); // R3

  AST_FREQ_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && cmd == 4'h2 && !rx_word[11]
      |=> half_now == {$past(held_byte), $past(rx_word[7:0])}); // R4

  AST_PHASE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && cmd == 4'h0 && rx_word[11]
      |=> phase_now == {$past(held_byte[3:0]), $past(rx_word[7:0])}); // R5

  AST_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && cmd == 4'h6
      |=> freq_sel_o == $past(rx_word[11]) && phase_sel_o == $past(rx_word[10:9])); // R7

  AST_SRC_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && rx_word[15:14] == 2'b10
      |=> {sync_o, src_reg_o} == $past(rx_word[13:12])); // R8

  AST_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && rx_word[15:14] == 2'b11
      |=> {sleep_o, core_reset_o, clear_o} == $past(rx_word[13:11])); // R9
endmodule

bind dds_cmd_slave dds_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .rx_word(rx_word),
  .held_byte(held_byte), .freq0_o(freq0_o), .freq1_o(freq1_o),
  .phase0_o(phase0_o), .phase1_o(phase1_o), .phase2_o(phase2_o), .phase3_o(phase3_o),
  .freq_sel_o(freq_sel_o), .phase_sel_o(phase_sel_o), .src_reg_o(src_reg_o),
  .sync_o(sync_o), .sleep_o(sleep_o), .core_reset_o(core_reset_o), .clear_o(clear_o)
);

// File: tb/test_dds_cmd_slave.sv
module test_dds_cmd_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [31:0] freq0_o, freq1_o;
  logic [11:0] phase0_o, phase1_o, phase2_o, phase3_o;
  logic freq_sel_o, src_reg_o, sync_o, sleep_o, core_reset_o, clear_o;
  logic [1:0] phase_sel_o;

  always #2 clk = ~clk;

  dds_cmd_slave i_dds_cmd_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .freq0_o(freq0_o), .freq1_o(freq1_o), .phase0_o(phase0_o), .phase1_o(phase1_o),
    .phase2_o(phase2_o), .phase3_o(phase3_o), .freq_sel_o(freq_sel_o),
    .phase_sel_o(phase_sel_o), .src_reg_o(src_reg_o), .sync_o(sync_o),
    .sleep_o(sleep_o), .core_reset_o(core_reset_o), .clear_o(clear_o)
  );

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] m_freq [2];
  logic [11:0] m_ph [4];
  logic [7:0]  m_hold;
  logic m_fsel, m_src, m_sync, m_sleep, m_rst, m_clr;
  logic [1:0] m_psel;
  int pend = 0;
  logic [15:0] pend_word;

  task automatic model_reset();
    m_freq[0] = 0; m_freq[1] = 0;
    for (int i = 0; i < 4; i++) m_ph[i] = 0;
    m_hold = 0; m_fsel = 0; m_psel = 0; m_src = 0; m_sync = 0;
    m_sleep = 1; m_rst = 1; m_clr = 1;
  endtask

  task automatic model_apply(input logic [15:0] w);
    int c, a, d;
    c = int'(w[15:12]); a = int'(w[11:8]); d = int'(w[7:0]);
    if (c >= 12) begin m_sleep = w[13]; m_rst = w[12]; m_clr = w[11]; end
    else if (c >= 8) begin m_sync = w[13]; m_src = w[12]; end
    else if (c == 1 || c == 3) m_hold = w[7:0];
    else if (c == 2 && a < 8) begin
      int sh;
      sh = (a % 4 >= 2) ? 16 : 0;
      m_freq[a / 4] = (m_freq[a / 4] & ~(32'hFFFF << sh)) |
                      ((32'(m_hold) * 256 + 32'(d)) << sh);
    end
    else if (c == 0 && a >= 8)
      m_ph[(a - 8) / 2] = 12'((int'(m_hold) % 16) * 256 + d);
    else if (c == 6) begin m_fsel = w[11]; m_psel = w[10:9]; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (pend > 0) begin
      pend--;
      if (pend == 0) model_apply(pend_word);
    end
  end

  function automatic logic [174:0] dut_vec();
    return {freq0_o, freq1_o, phase0_o, phase1_o, phase2_o, phase3_o, freq_sel_o,
            phase_sel_o, src_reg_o, sync_o, sleep_o, core_reset_o, clear_o, 48'h0};
  endfunction
  function automatic logic [174:0] ref_vec();
    return {m_freq[0], m_freq[1], m_ph[0], m_ph[1], m_ph[2], m_ph[3], m_fsel,
            m_psel, m_src, m_sync, m_sleep, m_rst, m_clr, 48'h0};
  endfunction

  // per-cycle comparison against the reference model (R11 timing included)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (dut_vec() !== ref_vec()) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", tag, dut_vec(), ref_vec());
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [15:0] w, input int nbits);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15 - i] : 1'b0;
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    if (nbits == 16) begin pend_word = w; pend = 3; end
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_val(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val("R1", {29'h0, sleep_o, core_reset_o, clear_o}, 32'h7);
    expect_val("R1", freq0_o | freq1_o, 32'h0);

    tag = "R9"; send(16'hC000, 16);
    expect_val("R9", {29'h0, sleep_o, core_reset_o, clear_o}, 32'h0);
    send(16'hE800, 16);
    expect_val("R9", {29'h0, sleep_o, core_reset_o, clear_o}, 32'h5);

    tag = "R3"; send(16'h3312, 16);
    expect_val("R3", freq0_o, 32'h0);

    tag = "R4"; send(16'h2234, 16);
    expect_val("R4", freq0_o, 32'h1234_0000);
    send(16'h3156, 16); send(16'h2078, 16);
    expect_val("R4", freq0_o, 32'h1234_5678);
    send(16'h37AB, 16); send(16'h26CD, 16); send(16'h35EF, 16); send(16'h2401, 16);
    expect_val("R4", freq1_o, 32'hABCD_EF01);

    tag = "R5"; send(16'h19FA, 16); send(16'h08BC, 16);
    expect_val("R5", 32'(phase0_o), 32'hABC);
    send(16'h1F05, 16); send(16'h0E66, 16);
    expect_val("R5", 32'(phase3_o), 32'h566);

    tag = "R6"; send(16'h0A11, 16);
    expect_val("R6", 32'(phase1_o), 32'h511);

    tag = "R2"; send(16'h2099, 15); send(16'h2099, 17);
    expect_val("R2", freq0_o, 32'h1234_5678);

    tag = "R7"; send(16'h6E00, 16);
    expect_val("R7", {29'h0, freq_sel_o, phase_sel_o}, 32'h7);
    send(16'h6200, 16);
    expect_val("R7", {29'h0, freq_sel_o, phase_sel_o}, 32'h1);

    tag = "R8"; send(16'hB000, 16);
    expect_val("R8", {30'h0, sync_o, src_reg_o}, 32'h3);
    send(16'h9000, 16);
    expect_val("R8", {30'h0, sync_o, src_reg_o}, 32'h1);
    send(16'h8000, 16);
    expect_val("R8", {30'h0, sync_o, src_reg_o}, 32'h0);

    tag = "R10"; send(16'h4A55, 16); send(16'h7FFF, 16); send(16'h5123, 16);
    send(16'h2977, 16); send(16'h0244, 16);
    expect_val("R10", freq0_o, 32'h1234_5678);
    expect_val("R10", 32'(phase1_o), 32'h511);
    expect_val("R10", {29'h0, freq_sel_o, phase_sel_o}, 32'h1);

    tag = "R11"; repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule